// File: doc/BRIEF.md
# Gap-Modulated Downlink Encoder

This block turns a reader command into a pattern of carrier gaps for a low-frequency tag. A one-cycle start pulse captures the command inputs and starts a frame. The frame opens with a long field-off interval. Every bit after that is sent as a field-on mark followed by a short field-off gap. The length of the mark carries the bit value: a short mark is a 0 and a long mark is a 1.

Three commands are supported: block write, block read and page-1 trace read. A write can carry a 32-bit password in front of its payload, and so can a read. Timing advances only on a tick input that pulses once per carrier cycle.

After a read or trace command the carrier is left on, so other logic can capture the tag's reply. After a write the carrier stays on for a programming interval and is then switched off. In both cases `done` pulses for one cycle when the frame ends.

Top module: `gap_downlink_enc`

## Requirements
- R1: While reset is asserted and right after it, `fieldOn`, `busy` and `done` are all 0.
- R2: A start pulse accepted in idle turns the field off on the capturing edge. The field then stays off for START_TICKS ticks, the start gap.
- R3: Each bit is a field-on mark followed by a field-off gap of GAP_TICKS ticks. The mark lasts ZERO_TICKS ticks for a 0 and ONE_TICKS ticks for a 1.
- R4: `cmdKind` 2'b00 selects a write frame. Its bits go out in this order: 1, 0, the optional password, a 0 lock bit, `dataWord` MSB first, then `blkIdx` MSB first.
- R5: `cmdKind` 2'b01 selects a read frame. Its bits go out in this order: 1, 0, the optional password, a 0 separator, then `blkIdx` MSB first. It has no data field.
- R6: `cmdKind` 2'b10 or 2'b11 selects a trace read frame, which is only the two bits 1, 1. The password, data and block inputs have no effect on it.
- R7: When `pwdEn` is 1, write and read frames carry all 32 bits of `pwdWord`, MSB first, right after the opcode. When `pwdEn` is 0 the password is left out.
- R8: The block field is 3 bits wide, and every value from 0 to 7 is sent exactly.
- R9: After the last gap of a write frame, the field is on for HOLD_TICKS ticks. The field is then switched off and `done` pulses.
- R10: After the last gap of a read or trace frame, the field turns on and `done` pulses on the same edge. The field then stays on while the block is idle.
- R11: A start pulse during a frame is ignored. Input changes after the capturing edge do not alter the frame in progress.
- R12: `busy` is high from the capturing edge until the frame ends. `done` is a one-cycle pulse during which `busy` is already low.
- R13: With `tick` low, the frame does not advance. A stall of S cycles in the start gap lengthens it by exactly S cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per carrier cycle |
| start | input | 1 | Starts a frame when idle |
| cmdKind | input | 2 | 00 write, 01 read, 1x trace read |
| dataWord | input | DATA_W | Write payload |
| pwdWord | input | PWD_W | Password |
| pwdEn | input | 1 | Include password |
| blkIdx | input | BLK_W | Block number |
| fieldOn | output | 1 | Carrier enable |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The field level is registered, so each phase boundary shows up one edge after the tick that ends the phase. The start gap begins on the very edge that captures `start`. When ticks arrive every cycle, each phase therefore spans exactly its tick count in cycles, and `done` appears on the same edge as the final field change.

The bench samples on the falling edge, starting with the first edge after the capture. It measures every field-on and field-off run in cycles, decodes the marks into bits and compares them with a frame built from the inputs. It also checks the programming hold and the level of the field when `done` is seen. A stalled tick must lengthen the start gap by exactly the number of cycles it was held low.

// File: rtl/gdl_pkg.sv
package gdl_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_MARK,
    PH_GAP,
    PH_HOLD
  } phase_t;

  typedef struct packed {
    logic load;
    logic shift;
  } dpStrobe_t;
endpackage

// File: rtl/gdl_frame.sv
module gdl_frame
  import gdl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PWD_W  = 32,
  parameter int BLK_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [1:0]        cmdKind,
  input  logic [DATA_W-1:0] dataWord,
  input  logic [PWD_W-1:0]  pwdWord,
  input  logic              pwdEn,
  input  logic [BLK_W-1:0]  blkIdx,
  output logic              curBit,
  output logic              frameEmpty,
  output logic              isWrite
);
  localparam int FRAME_W = 3 + PWD_W + DATA_W + BLK_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frameNx, shiftReg;
  logic [LEN_W-1:0]   lenNx, remain;
  logic               isWriteQ;

  // Frames are left-justified so that the bit on air is always the MSB.
  always_comb begin
    frameNx = '0;
    lenNx   = '0;
    if (cmdKind[1]) begin
      frameNx = {2'b11, {(FRAME_W-2){1'b0}}};
      lenNx   = LEN_W'(2);
    end else if (cmdKind[0]) begin
      if (pwdEn) begin
        frameNx = {2'b10, pwdWord, 1'b0, blkIdx, {DATA_W{1'b0}}};
        lenNx   = LEN_W'(3 + PWD_W + BLK_W);
      end else begin
        frameNx = {2'b10, 1'b0, blkIdx, {(PWD_W+DATA_W){1'b0}}};
        lenNx   = LEN_W'(3 + BLK_W);
      end
    end else begin
      if (pwdEn) begin
        frameNx = {2'b10, pwdWord, 1'b0, dataWord, blkIdx};
        lenNx   = LEN_W'(FRAME_W);
      end else begin
        frameNx = {2'b10, 1'b0, dataWord, blkIdx, {PWD_W{1'b0}}};
        lenNx   = LEN_W'(3 + DATA_W + BLK_W);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      remain   <= '0;
      isWriteQ <= 1'b0;
    end else if (strb.load) begin
      shiftReg <= frameNx;
      remain   <= lenNx;
      isWriteQ <= (cmdKind == 2'b00);
    end else if (strb.shift) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
      remain   <= remain - 1'b1;
    end
  end

  assign curBit     = shiftReg[FRAME_W-1];
  assign frameEmpty = (remain == '0);
  assign isWrite    = isWriteQ;

  // R3: a mark is only ever closed while a bit is still pending
  a_r3_shift_has_bits: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |-> !frameEmpty);

  // R11: loading and shifting never coincide
  a_r11_load_vs_shift: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load && strb.shift));

  // R6: a freshly loaded frame is never empty
  a_r6_load_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !frameEmpty);
endmodule

// File: rtl/gdl_seq.sv
module gdl_seq
  import gdl_pkg::*;
#(
  parameter int START_TICKS = 50,
  parameter int GAP_TICKS   = 20,
  parameter int ZERO_TICKS  = 16,
  parameter int ONE_TICKS   = 50,
  parameter int HOLD_TICKS  = 2500
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      start,
  input  logic      curBit,
  input  logic      frameEmpty,
  input  logic      isWrite,
  output dpStrobe_t strb,
  output logic      fieldOn,
  output logic      busy,
  output logic      done
);
  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_T = maxOf(maxOf(maxOf(START_TICKS, GAP_TICKS),
                                     maxOf(ZERO_TICKS, ONE_TICKS)), HOLD_TICKS);
  localparam int TIM_W = $clog2(MAX_T + 1);

  phase_t            phase, phaseNx;
  logic [TIM_W-1:0]  timer, timerNx;
  logic              fieldNx, doneNx, expire;

  function automatic logic [TIM_W-1:0] markLoad(logic b);
    return b ? TIM_W'(ONE_TICKS - 1) : TIM_W'(ZERO_TICKS - 1);
  endfunction

  assign expire = tick && (timer == '0);

  always_comb begin
    phaseNx = phase;
    timerNx = timer;
    fieldNx = fieldOn;
    doneNx  = 1'b0;
    strb    = '0;
    if (phase != PH_IDLE && tick && timer != '0) timerNx = timer - 1'b1;
    case (phase)
      PH_IDLE: if (start) begin
        strb.load = 1'b1;
        phaseNx   = PH_START;
        timerNx   = TIM_W'(START_TICKS - 1);
        fieldNx   = 1'b0;
      end
      PH_START: if (expire) begin
        phaseNx = PH_MARK;
        timerNx = markLoad(curBit);
        fieldNx = 1'b1;
      end
      PH_MARK: if (expire) begin
        phaseNx    = PH_GAP;
        timerNx    = TIM_W'(GAP_TICKS - 1);
        fieldNx    = 1'b0;
        strb.shift = 1'b1;
      end
      PH_GAP: if (expire) begin
        fieldNx = 1'b1;
        if (!frameEmpty) begin
          phaseNx = PH_MARK;
          timerNx = markLoad(curBit);
        end else if (isWrite) begin
          phaseNx = PH_HOLD;
          timerNx = TIM_W'(HOLD_TICKS - 1);
        end else begin
          phaseNx = PH_IDLE;
          doneNx  = 1'b1;
        end
      end
      PH_HOLD: if (expire) begin
        phaseNx = PH_IDLE;
        fieldNx = 1'b0;
        doneNx  = 1'b1;
      end
      default: phaseNx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      timer   <= '0;
      fieldOn <= 1'b0;
      done    <= 1'b0;
    end else begin
      phase   <= phaseNx;
      timer   <= timerNx;
      fieldOn <= fieldNx;
      done    <= doneNx;
    end
  end

  assign busy = (phase != PH_IDLE);

  // R2: an accepted start opens the start gap with the field off
  a_r2_start_gap_off: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && !fieldOn));

  // R11: no reload while a frame is running
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.load);

  // R12: done never overlaps busy
  a_r12_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R12: done only follows a running frame
  a_r12_done_after_frame: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  // R13: no tick, no progress
  a_r13_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick) |=> ($stable(fieldOn) && $stable(phase) && $stable(timer)));

  // R9: write frames end with the field off
  a_r9_write_ends_off: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(phase == PH_HOLD)) |-> !fieldOn);

  // R10: read and trace frames end with the field on
  a_r10_read_ends_on: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(phase == PH_GAP)) |-> fieldOn);
endmodule

// File: rtl/gap_downlink_enc.sv
module gap_downlink_enc
  import gdl_pkg::*;
#(
  parameter int START_TICKS = 50,
  parameter int GAP_TICKS   = 20,
  parameter int ZERO_TICKS  = 16,
  parameter int ONE_TICKS   = 50,
  parameter int HOLD_TICKS  = 2500,
  parameter int DATA_W      = 32,
  parameter int PWD_W       = 32,
  parameter int BLK_W       = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              start,
  input  logic [1:0]        cmdKind,
  input  logic [DATA_W-1:0] dataWord,
  input  logic [PWD_W-1:0]  pwdWord,
  input  logic              pwdEn,
  input  logic [BLK_W-1:0]  blkIdx,
  output logic              fieldOn,
  output logic              busy,
  output logic              done
);
  dpStrobe_t strb;
  logic      curBit, frameEmpty, isWrite;

  gdl_seq #(
    .START_TICKS(START_TICKS), .GAP_TICKS(GAP_TICKS), .ZERO_TICKS(ZERO_TICKS),
    .ONE_TICKS(ONE_TICKS), .HOLD_TICKS(HOLD_TICKS)
  ) i_seq (
    .clk(clk), .rstN(rstN), .tick(tick), .start(start), .curBit(curBit),
    .frameEmpty(frameEmpty), .isWrite(isWrite), .strb(strb),
    .fieldOn(fieldOn), .busy(busy), .done(done)
  );

  gdl_frame #(
    .DATA_W(DATA_W), .PWD_W(PWD_W), .BLK_W(BLK_W)
  ) i_frame (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdKind(cmdKind), .dataWord(dataWord),
    .pwdWord(pwdWord), .pwdEn(pwdEn), .blkIdx(blkIdx), .curBit(curBit),
    .frameEmpty(frameEmpty), .isWrite(isWrite)
  );
endmodule

// File: tb/test_gap_downlink_enc.sv
module test_gap_downlink_enc;
  localparam int ST = 5, GP = 3, ZT = 2, OT = 6, HD = 11;

  logic        clk = 1'b0, rstN = 1'b0, tick = 1'b1, start = 1'b0, pwdEn = 1'b0;
  logic [1:0]  cmdKind = 2'b00;
  logic [31:0] dataWord = '0, pwdWord = '0;
  logic [2:0]  blkIdx = '0;
  logic        fieldOn, busy, done;

  gap_downlink_enc #(
    .START_TICKS(ST), .GAP_TICKS(GP), .ZERO_TICKS(ZT), .ONE_TICKS(OT), .HOLD_TICKS(HD)
  ) i_gap_downlink_enc (
    .clk(clk), .rstN(rstN), .tick(tick), .start(start), .cmdKind(cmdKind),
    .dataWord(dataWord), .pwdWord(pwdWord), .pwdEn(pwdEn), .blkIdx(blkIdx),
    .fieldOn(fieldOn), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit expBits [0:127];
  bit gotBits [0:127];
  int expLen, gotLen;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void push(bit b);
    expBits[expLen] = b;
    expLen++;
  endfunction

  function automatic void buildExp(logic [1:0] k, logic [31:0] d, logic [31:0] p,
                                   bit pe, logic [2:0] b);
    expLen = 0;
    push(1'b1);
    if (k[1]) push(1'b1);
    else begin
      push(1'b0);
      if (pe) for (int i = 31; i >= 0; i--) push(p[i]);
      push(1'b0);
      if (k == 2'b00) for (int i = 31; i >= 0; i--) push(d[i]);
      for (int i = 2; i >= 0; i--) push(b[i]);
    end
  endfunction

  task automatic runFrame(input logic [1:0] k, input logic [31:0] d, input logic [31:0] p,
                          input bit pe, input logic [2:0] b, input int stall,
                          input int intr, input string req);
    int  runLen, startRun, badGaps, badBits, holdRun, mism;
    bit  prevLvl, lvl, firstRun, sawDone, busyBad, endLvl, trAtDone, isW;
    isW = (k == 2'b00);
    buildExp(k, d, p, pe, b);
    gotLen = 0; runLen = 0; startRun = -1; badGaps = 0; badBits = 0; holdRun = -1;
    firstRun = 1; sawDone = 0; busyBad = 0; endLvl = 0; trAtDone = 0;
    @(negedge clk);
    cmdKind = k; dataWord = d; pwdWord = p; pwdEn = pe; blkIdx = b;
    start = 1'b1; tick = (stall == 0);
    @(negedge clk);
    start = 1'b0;
    prevLvl = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      lvl = fieldOn;
      if (lvl != prevLvl) begin
        if (!prevLvl) begin
          if (firstRun) startRun = runLen;
          else if (runLen != GP) badGaps++;
          firstRun = 0;
        end else begin
          if (done && isW) holdRun = runLen;
          else if (runLen == ZT) begin gotBits[gotLen] = 1'b0; gotLen++; end
          else if (runLen == OT) begin gotBits[gotLen] = 1'b1; gotLen++; end
          else badBits++;
        end
        runLen = 0;
        prevLvl = lvl;
      end
      runLen++;
      if (done) begin if (busy) busyBad = 1; end
      else if (!busy) busyBad = 1;
      if (done) begin
        sawDone = 1; endLvl = lvl; trAtDone = (runLen == 1);
        break;
      end
      if (c == intr) begin
        start = 1'b1; cmdKind = ~k; dataWord = ~d; pwdWord = ~p; pwdEn = !pe; blkIdx = ~b;
      end else if (c == intr + 1) start = 1'b0;
      if (stall > 0 && c == stall) tick = 1'b1;
      @(negedge clk);
    end
    start = 1'b0; tick = 1'b1;
    mism = 0;
    for (int i = 0; i < 128; i++)
      if (i < expLen && i < gotLen && gotBits[i] != expBits[i]) mism++;
    check(sawDone, "R12", "frame completion", sawDone, 1);
    check(startRun == ST + stall, (stall > 0) ? "R13" : "R2", "start gap cycles",
          startRun, ST + stall);
    check(badGaps == 0, "R3", "gaps of wrong length", badGaps, 0);
    check(badBits == 0, "R3", "marks of wrong length", badBits, 0);
    check(gotLen == expLen, req, "bit count", gotLen, expLen);
    check(mism == 0, req, "bit mismatches", mism, 0);
    if (isW) check(holdRun == HD && endLvl == 0, "R9", "programming hold cycles",
                   holdRun, HD);
    else check(endLvl == 1 && trAtDone, "R10", "field on at done", endLvl, 1);
    check(!busyBad, "R12", "busy coherence", busyBad, 0);
    @(negedge clk);
    check(done == 0 && busy == 0, "R12", "done single pulse", done, 0);
    repeat (3) @(negedge clk);
    check(fieldOn == !isW, isW ? "R9" : "R10", "idle field level", fieldOn, !isW);
  endtask

  initial begin
    #1_500_000;
    nChecks++; nFails++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(fieldOn == 0 && busy == 0 && done == 0, "R1", "outputs in reset",
          {fieldOn, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(fieldOn == 0 && busy == 0 && done == 0, "R1", "outputs after reset",
          {fieldOn, busy, done}, 0);

    // R6 trace frames, both encodings
    runFrame(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 3'd7, 0, -5, "R6");
    runFrame(2'b11, 32'h0, 32'h0, 1'b0, 3'd0, 0, -5, "R6");

    // R5 R7 R8 reads, all blocks, password on/off
    for (int pe = 0; pe < 2; pe++)
      for (int b = 0; b < 8; b++)
        runFrame(2'b01, 32'h1357_9BDF, 32'hC3A5_0F1E ^ (32'h0101_0101 * b),
                 pe[0], 3'(b), 0, -5, "R5 R7 R8");

    // R4 R7 R8 writes, all blocks, password on/off
    for (int pe = 0; pe < 2; pe++)
      for (int b = 0; b < 8; b++)
        runFrame(2'b00, 32'h8000_0001 ^ (32'h1234_5678 * b), 32'h5A5A_F00F + b,
                 pe[0], 3'(b), 0, -5, "R4 R7 R8");

    // R11 start and input changes during a frame
    runFrame(2'b00, 32'hDEAD_BEEF, 32'h0F0F_0F0F, 1'b1, 3'd6, 0, 20, "R11");
    runFrame(2'b01, 32'h0, 32'hFFFF_0000, 1'b0, 3'd3, 0, 2, "R11");

    // R13 tick stall in the start gap
    runFrame(2'b01, 32'h0, 32'hA0A0_A0A0, 1'b1, 3'd5, 40, -5, "R13");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule